// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block paces the start-up of a switching regulator in units of switching cycles rather than clock time. Once the regulator is allowed to run, it counts switching-cycle strobes and raises a current-limit scale code through four equal plateaus. It reports the end of the ramp with a completion flag, which the output supervision logic uses to arm its undervoltage and power-good checks.

During the first plateau only, it also raises a flag that asks the switching control to double its minimum off-time. The run permit is the AND of three qualifiers: the reference is above its threshold, the gate-driver supply is out of lockout, and the analog supply is out of lockout. When any qualifier drops, the sequencer returns to idle. It starts again from zero when the permit comes back, which also covers the analog supply recovering from lockout.

Top module: `softstart_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ilim_code is 0, ss_done is 0 and dbl_toff is 0.
- R2: The sequencer runs only when ref_ok, drv_ok and ana_ok are all 1. If any of them is 0 at a clock edge, then after that edge ilim_code is 0, ss_done is 0 and dbl_toff is 0.
- R3: The cycle count advances only on a qualified switching-cycle strobe. Clock edges with no strobe change neither ilim_code nor ss_done.
- R4: ilim_code is 2'b00 (25%) for the first STEP_CYCLES counted strobes, then 2'b01 (50%), then 2'b10 (75%), then 2'b11 (100%). Each change comes on the strobe that completes a group of STEP_CYCLES, and the code only ever rises by one.
- R5: dbl_toff is 1 exactly while the ramp is in its first plateau. It is 0 in idle, in the later plateaus and after completion.
- R6: ss_done rises on the counted strobe numbered NUM_STEPS*STEP_CYCLES (440 with the defaults). It then stays at 1, with ilim_code held at 2'b11, as long as the permit stays high, whatever further strobes arrive.
- R7: Strobes are not counted while the permit is low, nor in the first clock cycle in which the permit is high again.
- R8: When the permit returns after being lost, including when ana_ok rises after a lockout, the ramp restarts from zero: it needs the full STEP_CYCLES strobes again before the code reaches 2'b01.
- R9: With STB_EDGE=1, a strobe held high over several clocks counts once, on its rising edge. With STB_EDGE=0, every clock with the strobe high counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ok | input | 1 | Reference above its enable threshold |
| drv_ok | input | 1 | Gate-driver supply out of lockout |
| ana_ok | input | 1 | Analog supply out of lockout |
| cyc_stb | input | 1 | Switching-cycle strobe |
| ilim_code | output | CODE_W (2) | Current-limit scale code (00=25%, 01=50%, 10=75%, 11=100%) |
| dbl_toff | output | 1 | Request for a doubled minimum off-time |
| ss_done | output | 1 | Soft-start complete; arms the UV and power-good supervision |

## Verification
The bench builds the block with STEP_CYCLES=7, NUM_STEPS=4 and STB_EDGE=1. The short plateaus put every plateau boundary and the completion strobe (number 28) within a few dozen strobes, so each change of the code is checked one strobe before and at the boundary. The edge-detecting strobe variant lets a long-held strobe show that it counts once. The run-permit drops are placed mid-ramp and after completion, to show that the ramp restarts from zero and that strobes in idle are ignored.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_RAMP = 2'd1,
      SS_DONE = 2'd2
   } ss_state_e;
endpackage

// File: rtl/ss_permit.sv
module ss_permit (
   input  logic ref_ok,
   input  logic drv_ok,
   input  logic ana_ok,
   output logic run_en
);
   assign run_en = ref_ok & drv_ok & ana_ok;
endmodule

// File: rtl/ss_stb_cond.sv
module ss_stb_cond #(
   parameter bit STB_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_stb,
   output logic adv
);
   generate
      if (STB_EDGE) begin : g_edge
         logic stb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= cyc_stb;
         end
         assign adv = cyc_stb & ~stb_q;
      end else begin : g_pulse
         assign adv = cyc_stb;
      end
   endgenerate
endmodule

// File: rtl/ss_step_ctr.sv
module ss_step_ctr
   import ss_pkg::*;
#(
   parameter int STEP_CYCLES = 110,
   parameter int NUM_STEPS   = 4,
   localparam int CNT_W      = $clog2(STEP_CYCLES),
   localparam int CODE_W     = $clog2(NUM_STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              adv,
   output logic [CODE_W-1:0] step,
   output logic              ramping,
   output logic              done
);
   localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(STEP_CYCLES - 1);
   localparam logic [CODE_W-1:0] LAST_STEP = CODE_W'(NUM_STEPS - 1);

   ss_state_e         st;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SS_IDLE;
         cnt  <= '0;
         step <= '0;
      end else if (!run_en) begin
         st   <= SS_IDLE;
         cnt  <= '0;
         step <= '0;
      end else begin
         unique case (st)
            SS_IDLE: st <= SS_RAMP;
            SS_RAMP: begin
               if (adv) begin
                  if (cnt == LAST_CNT) begin
                     cnt <= '0;
                     if (step == LAST_STEP) st <= SS_DONE;
                     else                   step <= step + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            SS_DONE: st <= SS_DONE;
            default: st <= SS_IDLE;
         endcase
      end
   end

   assign ramping = (st == SS_RAMP);
   assign done    = (st == SS_DONE);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
   parameter int  STEP_CYCLES = 110,
   parameter int  NUM_STEPS   = 4,
   parameter bit  STB_EDGE    = 1'b0,
   localparam int CODE_W      = $clog2(NUM_STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_ok,
   input  logic              drv_ok,
   input  logic              ana_ok,
   input  logic              cyc_stb,
   output logic [CODE_W-1:0] ilim_code,
   output logic              dbl_toff,
   output logic              ss_done
);
   generate
      if (STEP_CYCLES < 2) begin : g_bad_step
         $error("softstart_seq: STEP_CYCLES must be at least 2");
      end
      if (NUM_STEPS < 2 || (NUM_STEPS & (NUM_STEPS - 1)) != 0) begin : g_bad_num
         $error("softstart_seq: NUM_STEPS must be a power of two, at least 2");
      end
   endgenerate

   logic              run_en;
   logic              adv;
   logic [CODE_W-1:0] step;
   logic              ramping;

   ss_permit u_permit (
      .ref_ok (ref_ok),
      .drv_ok (drv_ok),
      .ana_ok (ana_ok),
      .run_en (run_en)
   );

   ss_stb_cond #(.STB_EDGE(STB_EDGE)) u_stb (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_stb (cyc_stb),
      .adv     (adv)
   );

   ss_step_ctr #(.STEP_CYCLES(STEP_CYCLES), .NUM_STEPS(NUM_STEPS)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .adv     (adv),
      .step    (step),
      .ramping (ramping),
      .done    (ss_done)
   );

   assign ilim_code = step;
   assign dbl_toff  = ramping && (step == '0);
endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
   parameter int CODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_ok,
   input logic              drv_ok,
   input logic              ana_ok,
   input logic              cyc_stb,
   input logic [CODE_W-1:0] ilim_code,
   input logic              dbl_toff,
   input logic              ss_done
);
   logic en;
   logic seen;
   assign en = ref_ok & drv_ok & ana_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R2
   permit_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (ilim_code == '0 && !ss_done && !dbl_toff));

   // R3
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && en && !cyc_stb) |=> ($stable(ilim_code) && $stable(ss_done)));

   // R4
   code_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(en) && ilim_code != $past(ilim_code)) |-> (ilim_code == $past(ilim_code) + 1'b1));

   // R5
   dbl_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_toff |-> (ilim_code == '0 && !ss_done));

   // R6
   done_full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done |-> (ilim_code == '1));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_done && en) |=> ss_done);
endmodule

bind softstart_seq ss_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_ok    (ref_ok),
   .drv_ok    (drv_ok),
   .ana_ok    (ana_ok),
   .cyc_stb   (cyc_stb),
   .ilim_code (ilim_code),
   .dbl_toff  (dbl_toff),
   .ss_done   (ss_done)
);

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
   localparam int STEP = 7;
   localparam int NST  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_ok = 1'b0, drv_ok = 1'b0, ana_ok = 1'b0;
   logic       cyc_stb = 1'b0;
   logic [1:0] ilim_code;
   logic       dbl_toff, ss_done;
   int         n_chk = 0, n_fail = 0;
   bit         ended = 1'b0;

   always #2 clk = ~clk;

   softstart_seq #(.STEP_CYCLES(STEP), .NUM_STEPS(NST), .STB_EDGE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .drv_ok(drv_ok), .ana_ok(ana_ok),
      .cyc_stb(cyc_stb), .ilim_code(ilim_code), .dbl_toff(dbl_toff), .ss_done(ss_done)
   );

   // Compares {dbl_toff, ss_done, ilim_code}
   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {dbl_toff, ss_done, ilim_code};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {dbl,done,code} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) cyc_stb = 1'b1;
         @(negedge clk) cyc_stb = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic permit(input logic r, input logic d, input logic a);
      @(negedge clk);
      ref_ok = r; drv_ok = d; ana_ok = a;
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk); chk("R1 in reset", 4'b0000);
      rst_n = 1'b1;
      @(negedge clk); chk("R1 after reset", 4'b0000);
   endtask

   task automatic t_idle_strobes;
      ref_ok = 1'b0; drv_ok = 1'b1; ana_ok = 1'b1;
      pulse(3);
      chk("R7 strobes with permit low", 4'b0000);
      chk("R2 permit low idle", 4'b0000);
   endtask

   task automatic t_full_ramp;
      // first cycle with the permit high: strobe not counted (R7)
      @(negedge clk) begin ref_ok = 1'b1; cyc_stb = 1'b1; end
      @(negedge clk) cyc_stb = 1'b0;
      @(negedge clk);
      chk("R5 first plateau dbl", 4'b1000);
      repeat (20) @(negedge clk);
      chk("R3 clocks without strobe", 4'b1000);
      pulse(STEP - 1);
      chk("R7/R4 one strobe before 50%", 4'b1000);
      pulse(1);
      chk("R4 50% code, R5 dbl cleared", 4'b0001);
      pulse(STEP);
      chk("R4 75% code", 4'b0010);
      pulse(STEP);
      chk("R4 100% code, not done", 4'b0011);
      pulse(STEP - 1);
      chk("R6 one strobe before done", 4'b0011);
      pulse(1);
      chk("R6 done at final strobe", 4'b0111);
      pulse(5);
      chk("R6 done holds", 4'b0111);
   endtask

   task automatic t_held_strobe;
      permit(1'b1, 1'b0, 1'b1);
      chk("R2 driver supply low", 4'b0000);
      permit(1'b1, 1'b1, 1'b1);
      @(negedge clk) cyc_stb = 1'b1;
      repeat (10) @(negedge clk);
      cyc_stb = 1'b0;
      @(negedge clk);
      pulse(STEP - 2);
      chk("R9 held strobe counted once", 4'b1000);
      pulse(1);
      chk("R9 held strobe plus pulses", 4'b0001);
   endtask

   task automatic t_restart;
      pulse(STEP);
      chk("R4 mid-ramp before drop", 4'b0010);
      permit(1'b1, 1'b1, 1'b0);
      chk("R2 analog supply low", 4'b0000);
      permit(1'b1, 1'b1, 1'b1);
      chk("R8 restart from zero", 4'b1000);
      pulse(STEP - 1);
      chk("R8 full plateau needed again", 4'b1000);
      pulse(1);
      chk("R8 plateau after restart", 4'b0001);
   endtask

   initial begin
      #(200000 * 4);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle_strobes();
      t_full_ramp();
      t_held_strobe();
      t_restart();
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule